// File: doc/BRIEF.md
# Synchronous DRAM Burst Write Sequencer

This block sits on the device side of a synchronous DRAM and turns write commands from the command pins into a stream of writes to the internal column array. It decodes a write from the chip-select and three strobe pins. It takes the first data word in the same cycle as the command, because writes carry no latency. It then produces one column address and one array write per clock until the burst length that was selected with the command has been reached.

Column addresses advance upward from the starting column and wrap inside the aligned block whose size is the burst length. The upper column bits stay fixed for the whole burst. If a new write arrives while a burst is still running, the rest of the old burst is dropped and a fresh burst starts at the new column. Any other command leaves a running burst alone, and any data word that arrives after a burst has ended is discarded.

The array-side outputs are combinational from the command pins and the burst state. The array therefore registers each beat on the same rising edge that registers the command or data word.

Top module: `sdram_burst_writer`

## Requirements
- R1: A write is decoded when `cs_n`=0, `ras_n`=1, `cas_n`=0 and `we_n`=0 in the cycle before a rising edge. In that same cycle `arr_we`=1, `arr_col`=`col_in` and `arr_data`=`dq_in`.
- R2: No other pin combination raises `arr_we` while no burst is running. This covers `cs_n`=1 with any strobes, the read pattern (1,0,1), the activate pattern (0,1,1) and the pattern (0,0,1), each written as `ras_n`,`cas_n`,`we_n`.
- R3: After a write, one further beat follows on each clock with `arr_we`=1 and `arr_data`=`dq_in`, so the burst covers exactly burst-length cycles including the command cycle.
- R4: `bl_sel` is sampled with the write command and selects the burst length: 0 selects 1, 1 selects 2, 2 selects 4 and 3 selects 8. A length-1 burst ends in the command cycle.
- R5: On beat k (k=0 for the command cycle), `arr_col` equals the start column with its low log2(length) bits replaced by (start low bits + k) mod length. For example, length 4 from column 2 gives 2, 3, 0, 1.
- R6: Once the last beat has been written, `arr_we` stays 0 and data on `dq_in` causes no array write until the next write command.
- R7: A write during a running burst, including one exactly one clock after the previous write, drops the remaining old beats. It restarts at its own column and runs for its own full length.
- R8: A non-write command during a burst neither stops it nor changes its column sequence.
- R9: While `rst_n` is low, and for two rising edges after it rises, `arr_we` is 0 and no burst starts, even if a write pattern is present on the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released internally on the clock |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| col_in | input | COL_W (8) | Column address presented with a command |
| dq_in | input | DATA_W (16) | Write data bus |
| bl_sel | input | 2 | Burst length code, static between writes |
| arr_we | output | 1 | Array write strobe for the current beat |
| arr_col | output | COL_W (8) | Array column for the current beat |
| arr_data | output | DATA_W (16) | Array data for the current beat |

## Verification
Every array output is due in the very cycle of the stimulus that causes it. The command beat depends only on the pins, and each later beat depends on state captured at the preceding edge. Burst progress therefore shows one edge after the command. The bench drives the pins just after the falling edge and compares the outputs one nanosecond later, before the rising edge that commits the beat. Its reference model then advances at that rising edge, so each comparison sees exactly the state that the preceding edges have built.

// File: rtl/sdram_wr_pkg.sv
package sdram_wr_pkg;

  // Command classes seen on the control pins.
  typedef enum logic [1:0] {
    CMD_DESEL = 2'd0,
    CMD_NOP   = 2'd1,
    CMD_WRITE = 2'd2,
    CMD_OTHER = 2'd3
  } cmd_kind_t;

  // Width of the burst length code (lengths 1, 2, 4, 8).
  localparam int unsigned BL_SEL_W = 2;

endpackage

// File: rtl/wr_cmd_decode.sv
module wr_cmd_decode
  import sdram_wr_pkg::*;
#(
  parameter int unsigned IDX_W = 3
) (
  input  logic                cs_n,
  input  logic                ras_n,
  input  logic                cas_n,
  input  logic                we_n,
  input  logic [BL_SEL_W-1:0] bl_sel,
  output cmd_kind_t           cmd_kind,
  output logic                wr_cmd,
  output logic [IDX_W-1:0]    len_mask
);

  int unsigned sel_eff;

  always_comb begin
    if (cs_n) begin
      cmd_kind = CMD_DESEL;
    end else begin
      unique case ({ras_n, cas_n, we_n})
        3'b111:  cmd_kind = CMD_NOP;
        3'b100:  cmd_kind = CMD_WRITE;
        default: cmd_kind = CMD_OTHER;
      endcase
    end
    wr_cmd = (cmd_kind == CMD_WRITE);
  end

  // Length code to wrap mask; codes beyond the index width clamp to the maximum.
  always_comb begin
    sel_eff = (int'(bl_sel) > int'(IDX_W)) ? IDX_W : int'(bl_sel);
    len_mask = IDX_W'((32'd1 << sel_eff) - 32'd1);
  end

endmodule

// File: rtl/wr_col_gen.sv
module wr_col_gen #(
  parameter int unsigned COL_W = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic [COL_W-1:0] base_col,
  input  logic [IDX_W-1:0] beat,
  input  logic [IDX_W-1:0] len_mask,
  output logic [COL_W-1:0] beat_col
);

  logic [IDX_W-1:0] low_sum;

  always_comb begin
    low_sum = base_col[IDX_W-1:0] + beat;
  end

  // Bits inside the burst window take the incremented value, the rest hold.
  for (genvar i = 0; i < IDX_W; i++) begin : g_wrap_bit
    assign beat_col[i] = len_mask[i] ? low_sum[i] : base_col[i];
  end

  assign beat_col[COL_W-1:IDX_W] = base_col[COL_W-1:IDX_W];

endmodule

// File: rtl/wr_burst_ctrl.sv
module wr_burst_ctrl #(
  parameter int unsigned COL_W = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [IDX_W-1:0] start_mask,
  output logic             busy,
  output logic [COL_W-1:0] base_col,
  output logic [IDX_W-1:0] beat,
  output logic [IDX_W-1:0] len_mask
);

  logic             busy_q, busy_d;
  logic [COL_W-1:0] base_q, base_d;
  logic [IDX_W-1:0] beat_q, beat_d;
  logic [IDX_W-1:0] mask_q, mask_d;
  logic             upd_en;

  // Next state: a write always restarts; otherwise step the running burst.
  always_comb begin
    busy_d = busy_q;
    base_d = base_q;
    beat_d = beat_q;
    mask_d = mask_q;
    upd_en = start | busy_q;
    if (start) begin
      base_d = start_col;
      mask_d = start_mask;
      beat_d = IDX_W'(1);
      busy_d = (start_mask != '0);
    end else if (busy_q) begin
      beat_d = beat_q + IDX_W'(1);
      if (beat_q == mask_q) begin
        busy_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      base_q <= '0;
      beat_q <= '0;
      mask_q <= '0;
    end else if (upd_en) begin
      busy_q <= busy_d;
      base_q <= base_d;
      beat_q <= beat_d;
      mask_q <= mask_d;
    end
  end

  assign busy     = busy_q;
  assign base_col = base_q;
  assign beat     = beat_q;
  assign len_mask = mask_q;

  // R3: a non-final beat is followed by the next beat index.
  p_beat_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !start && beat_q != mask_q) |=>
      (busy_q && beat_q == $past(beat_q) + IDX_W'(1)));

  // R4: a length-1 burst leaves nothing running.
  p_single_beat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && start_mask == '0) |=> !busy_q);

  // R6: the last beat ends the burst.
  p_burst_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !start && beat_q == mask_q) |=> !busy_q);

  // R7: a write captures its own column and restarts the beat count.
  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (base_q == $past(start_col) && beat_q == IDX_W'(1)
               && mask_q == $past(start_mask)));

  // R8: other commands leave the running burst's column window alone.
  p_hold_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !start) |=> ($stable(base_q) && $stable(mask_q)));

endmodule

// File: rtl/sdram_burst_writer.sv
module sdram_burst_writer
  import sdram_wr_pkg::*;
#(
  parameter int unsigned COL_W   = 8,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned MAX_BL  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n,
  input  logic                ras_n,
  input  logic                cas_n,
  input  logic                we_n,
  input  logic [COL_W-1:0]    col_in,
  input  logic [DATA_W-1:0]   dq_in,
  input  logic [BL_SEL_W-1:0] bl_sel,
  output logic                arr_we,
  output logic [COL_W-1:0]    arr_col,
  output logic [DATA_W-1:0]   arr_data
);

  localparam int unsigned IDX_W = $clog2(MAX_BL);

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_sync_q;
  logic       rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_ok = rst_sync_q[1];

  cmd_kind_t        cmd_kind;
  logic             wr_cmd;
  logic             start;
  logic [IDX_W-1:0] cmd_mask;
  logic             busy;
  logic [COL_W-1:0] base_col;
  logic [IDX_W-1:0] beat;
  logic [IDX_W-1:0] run_mask;
  logic [COL_W-1:0] beat_col;

  wr_cmd_decode #(.IDX_W(IDX_W)) u_dec (
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .bl_sel   (bl_sel),
    .cmd_kind (cmd_kind),
    .wr_cmd   (wr_cmd),
    .len_mask (cmd_mask)
  );

  assign start = wr_cmd & rst_ok;

  wr_burst_ctrl #(.COL_W(COL_W), .IDX_W(IDX_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_ok),
    .start      (start),
    .start_col  (col_in),
    .start_mask (cmd_mask),
    .busy       (busy),
    .base_col   (base_col),
    .beat       (beat),
    .len_mask   (run_mask)
  );

  wr_col_gen #(.COL_W(COL_W), .IDX_W(IDX_W)) u_col (
    .base_col (base_col),
    .beat     (beat),
    .len_mask (run_mask),
    .beat_col (beat_col)
  );

  // The command beat comes straight from the pins; later beats from state.
  always_comb begin
    arr_we   = start | (busy & rst_ok);
    arr_col  = start ? col_in : beat_col;
    arr_data = dq_in;
  end

  // R5: continuation beats never leave the aligned window of the burst.
  p_window_r5: assert property (@(posedge clk) disable iff (!rst_ok)
    (arr_we && !wr_cmd) |-> (arr_col[COL_W-1:IDX_W] == base_col[COL_W-1:IDX_W]));

  // R2: a non-write command with no burst running causes no array write.
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    (cmd_kind != CMD_WRITE && !busy) |-> !arr_we);

  // R9: nothing is written while the reset is still held internally.
  p_reset_quiet_r9: assert property (@(posedge clk)
    !rst_ok |-> !arr_we);

endmodule

// File: tb/sdram_burst_writer_test.sv
`timescale 1ns/1ps
module sdram_burst_writer_test;

  localparam real HALF = 2.5;

  logic        clk;
  logic        rst_n;
  logic        cs_n, ras_n, cas_n, we_n;
  logic [7:0]  col_in;
  logic [15:0] dq_in;
  logic [1:0]  bl_sel;
  logic        arr_we;
  logic [7:0]  arr_col;
  logic [15:0] arr_data;

  int nvec  = 0;
  int nfail = 0;
  bit done  = 0;

  // Reference model state
  bit live = 0;
  int m_base, m_len, m_idx, m_rem;
  int tick = 0;

  sdram_burst_writer uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .col_in(col_in), .dq_in(dq_in), .bl_sel(bl_sel),
    .arr_we(arr_we), .arr_col(arr_col), .arr_data(arr_data)
  );

  initial clk = 1'b0;
  always #(HALF) clk = ~clk;

  task automatic step(input string tag, input bit c, input bit r, input bit ca,
                      input bit w, input int col, input int bl);
    bit is_wr;
    bit e_we;
    int e_col;
    int dq;
    @(negedge clk);
    tick++;
    dq = (16'h5A00 + tick * 37) & 16'hFFFF;
    cs_n = c; ras_n = r; cas_n = ca; we_n = w;
    col_in = col[7:0]; dq_in = dq[15:0]; bl_sel = bl[1:0];
    #1;
    is_wr = live && !c && r && !ca && !w;
    e_we = is_wr || (live && m_rem > 0);
    if (is_wr) e_col = col & 255;
    else e_col = (m_base & ~(m_len - 1) & 255) | ((m_base + m_idx) & (m_len - 1));
    nvec++;
    if (arr_we !== e_we ||
        (e_we && (arr_col !== e_col[7:0] || arr_data !== dq[15:0]))) begin
      nfail++;
      $display("FAIL %s: we=%0b col=%02h data=%04h expected we=%0b col=%02h data=%04h",
               tag, arr_we, arr_col, arr_data, e_we, e_col[7:0], dq[15:0]);
    end
    @(posedge clk);
    if (is_wr) begin
      m_base = col & 255; m_len = 1 << bl; m_idx = 1; m_rem = m_len - 1;
    end else if (live && m_rem > 0) begin
      m_idx++; m_rem--;
    end
  endtask

  task automatic wr(input string tag, input int col, input int bl);
    step(tag, 0, 1, 0, 0, col, bl);
  endtask

  task automatic nop(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, 0, 1, 1, 1, 8'hEE, 3);
  endtask

  initial begin
    m_base = 0; m_len = 1; m_idx = 0; m_rem = 0;
    rst_n = 1'b0;
    cs_n = 1; ras_n = 1; cas_n = 1; we_n = 1; col_in = 0; dq_in = 0; bl_sel = 0;
    // R9: reset state, write pattern ignored while reset is held
    step("R9", 1, 1, 1, 1, 0, 0);
    step("R9", 0, 1, 0, 0, 8'h44, 2);
    @(negedge clk); rst_n = 1'b1;
    step("R9", 0, 1, 0, 0, 8'h45, 2);   // sync stage still low
    nop("R9", 2);
    live = 1;
    // R1 / R4: length 1
    wr("R1", 8'h10, 0);
    nop("R6", 2);
    // R4: length 2 from an odd column (wrap)
    wr("R4", 8'h21, 1);
    nop("R4", 3);
    // R5: length 4 from column 2 -> 2,3,0,1
    wr("R5", 8'h42, 2);
    nop("R5", 3);
    nop("R6", 3);
    // R5: length 8 from column 5
    wr("R5", 8'h85, 3);
    nop("R5", 7);
    nop("R6", 2);
    // R2: non-write patterns while idle
    step("R2", 1, 1, 0, 0, 8'h11, 2);
    step("R2", 0, 1, 0, 1, 8'h12, 2);
    step("R2", 0, 0, 1, 1, 8'h13, 2);
    step("R2", 0, 0, 0, 1, 8'h14, 2);
    step("R2", 1, 0, 0, 0, 8'h15, 2);
    // R8: other commands inside a burst
    wr("R8", 8'h13, 2);
    step("R8", 1, 1, 0, 0, 8'hF0, 0);
    step("R8", 0, 1, 0, 1, 8'hF1, 0);
    step("R8", 0, 0, 1, 1, 8'hF2, 0);
    nop("R6", 2);
    // R7: interrupt one clock after the previous write
    wr("R7", 8'h30, 2);
    wr("R7", 8'h5A, 2);
    nop("R7", 3);
    nop("R6", 2);
    // R7: interrupt with a different length, later in the burst
    wr("R7", 8'h60, 3);
    nop("R7", 3);
    wr("R7", 8'h73, 1);
    nop("R7", 1);
    nop("R6", 2);
    // R3: back-to-back single and long bursts
    wr("R3", 8'h01, 0);
    wr("R3", 8'h02, 0);
    wr("R3", 8'hFE, 2);
    nop("R3", 3);
    wr("R3", 8'hC7, 3);
    nop("R3", 7);
    nop("R6", 3);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

endmodule